// File: doc/BRIEF.md
# Exception Vectoring and Alignment Unit

This unit sits between a small load/store processor core and its memory bus. Every cycle it looks at the current data access (address, size, valid strobe and whether the address decoder found a memory or register region behind it) and at the instruction-side flags: an unrecognised opcode, a system-call instruction, a trap instruction, and tick-timer expiry. When any of these calls for an exception, it picks one cause by fixed priority and reports it in the same cycle. It also drives the handler address from a fixed sparse vector map, so the core loads it into its PC at the next edge and runs the handler on the following cycle.

On that same edge the unit copies the core's PC and status word into two shadow registers and forces the processor into supervisor mode. A return-from-exception request redirects the core to the saved PC and sets the mode from the supervisor bit of the saved status word. The mode is kept in a two-state machine. ST_SUPER is entered on reset. It has two transitions. T_EXC goes to ST_SUPER from either state on any exception. T_RET goes from either state to ST_SUPER or ST_USER according to the saved supervisor bit, and applies only when no exception is raised in the same cycle. With no request the state holds.

Top module: `exc_vector_unit`

## Requirements
- R1: While and right after reset the unit is in supervisor mode (`supervisor`=1), `saved_pc` and `saved_status` are zero, and `exc_taken` is low when no cause is present.
- R2: A valid access with `mem_region_hit`=0 raises a bus error: `exc_taken`=1, `exc_cause`=1, `redirect_pc`=VEC_BASE+0x200, in the same cycle.
- R3: Access size is coded in `mem_size` as 0=8-bit, 1=16-bit, 2 or 3=32-bit. A valid, decoded 16-bit access with address bit 0 set, or a 32-bit access with either of address bits 1:0 set, raises an alignment fault (`exc_cause`=2, vector VEC_BASE+0x600). An 8-bit access never does.
- R4: `fetch_illegal` raises an illegal-instruction exception, with `exc_cause`=3 and vector VEC_BASE+0x700.
- R5: `insn_syscall` gives `exc_cause`=4 with vector VEC_BASE+0xC00. `insn_trap` gives `exc_cause`=5 with vector VEC_BASE+0xE00.
- R6: `tick_expired` gives `exc_cause`=6 with vector VEC_BASE+0x500.
- R7: When several causes occur together, exactly one is reported. The order, highest first, is: bus error, alignment, illegal instruction, system call, trap, tick.
- R8: At the clock edge ending a cycle with `exc_taken`=1, `saved_pc` takes `pc_in` and `saved_status` takes `status_in` unchanged.
- R9: After the clock edge ending a cycle with `exc_taken`=1, `supervisor` is 1, whatever the previous mode.
- R10: `eret` without an exception drives `redirect_valid`=1 and `redirect_pc`=`saved_pc` in the same cycle. After the edge, `supervisor` equals bit SUP_BIT (0 by default) of `saved_status`. An exception in the same cycle overrides `eret`.
- R11: With no cause present and `eret` low, `exc_taken` and `redirect_valid` are low and the saved registers and mode hold. A misaligned or undecoded address with `mem_valid`=0 raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_valid | input | 1 | Data access in progress this cycle |
| mem_addr | input | AW | Data access byte address |
| mem_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| mem_region_hit | input | 1 | Address decoder found a populated region |
| fetch_illegal | input | 1 | Fetched instruction not recognised |
| insn_syscall | input | 1 | System-call instruction executing |
| insn_trap | input | 1 | Trap instruction executing |
| tick_expired | input | 1 | Tick timer expired |
| eret | input | 1 | Return-from-exception request |
| pc_in | input | AW | Core PC of the current instruction |
| status_in | input | SW | Core status word |
| exc_taken | output | 1 | An exception is taken this cycle |
| exc_cause | output | 3 | Cause code of the taken exception (0 none) |
| redirect_valid | output | 1 | Core must load `redirect_pc` at the next edge |
| redirect_pc | output | AW | Vector address or saved PC |
| saved_pc | output | AW | Shadow copy of the PC at the last exception |
| saved_status | output | SW | Shadow copy of the status at the last exception |
| supervisor | output | 1 | 1 in supervisor mode, 0 in user mode |

## Verification
Every combination of the six causes is driven, so a design that ranks any pair the wrong way reports the wrong vector. A wrong order between bus error and alignment is the likely one, since a single undecoded, misaligned access raises both. Every size code is swept against every low address pattern, which catches a byte access that faults, or a word check that looks at only one address bit. Return-from-exception is driven once with the saved supervisor bit clear and once with it set, and once in the same cycle as an illegal instruction. A unit that let the return win there would skip the fault, and one that ignored the saved bit would never reach user mode. Access strobes low with bad addresses show that gating by `mem_valid` is in place.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NUM_SRC = 6;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_BUS     = 3'd1,
        CAUSE_ALIGN   = 3'd2,
        CAUSE_ILLEGAL = 3'd3,
        CAUSE_SYSCALL = 3'd4,
        CAUSE_TRAP    = 3'd5,
        CAUSE_TICK    = 3'd6
    } exc_cause_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_USER  = 1'b0,
        ST_SUPER = 1'b1
    } mode_e;

    function automatic logic [11:0] vec_offset(exc_cause_e c);
        logic [11:0] off;
        case (c)
            CAUSE_BUS:     off = 12'h200;
            CAUSE_TICK:    off = 12'h500;
            CAUSE_ALIGN:   off = 12'h600;
            CAUSE_ILLEGAL: off = 12'h700;
            CAUSE_SYSCALL: off = 12'hC00;
            CAUSE_TRAP:    off = 12'hE00;
            default:       off = 12'h000;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/exc_align_check.sv
module exc_align_check #(
    parameter int AW = 32
) (
    input  logic                  valid,
    input  exc_pkg::acc_size_e    size,
    input  logic [1:0]            addr_lo,
    output logic                  misaligned
);
    import exc_pkg::*;

    logic bad;

    always_comb begin
        case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = addr_lo[0];
            default: bad = |addr_lo;
        endcase
        misaligned = valid & bad;
    end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    assign grant[0] = req[0];
    for (genvar i = 1; i < N; i++) begin : g_rank
        assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
    assign any = |req;

endmodule

// File: rtl/exc_state_save.sv
module exc_state_save #(
    parameter int AW      = 32,
    parameter int SW      = 8,
    parameter int SUP_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          ret,
    input  logic [AW-1:0] pc_in,
    input  logic [SW-1:0] status_in,
    output logic [AW-1:0] epc_q,
    output logic [SW-1:0] esr_q,
    output logic          supervisor
);
    import exc_pkg::*;

    mode_e state_q, state_d;
    mode_e ret_target;

    assign ret_target = esr_q[SUP_BIT] ? ST_SUPER : ST_USER;

    // next-state: T_EXC beats T_RET, otherwise hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPER: begin
                if (take)     state_d = ST_SUPER;
                else if (ret) state_d = ret_target;
            end
            ST_USER: begin
                if (take)     state_d = ST_SUPER;
                else if (ret) state_d = ret_target;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SUPER;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q <= '0;
            esr_q <= '0;
        end else if (take) begin
            epc_q <= pc_in;
            esr_q <= status_in;
        end
    end

    always_comb begin
        supervisor = (state_q == ST_SUPER);
    end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
    parameter int            AW       = 32,
    parameter int            SW       = 8,
    parameter int            SUP_BIT  = 0,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_addr,
    input  logic [1:0]    mem_size,
    input  logic          mem_region_hit,
    input  logic          fetch_illegal,
    input  logic          insn_syscall,
    input  logic          insn_trap,
    input  logic          tick_expired,
    input  logic          eret,
    input  logic [AW-1:0] pc_in,
    input  logic [SW-1:0] status_in,
    output logic          exc_taken,
    output logic [2:0]    exc_cause,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic [AW-1:0] saved_pc,
    output logic [SW-1:0] saved_status,
    output logic          supervisor
);
    import exc_pkg::*;

    logic               misaligned;
    logic [NUM_SRC-1:0] req, grant;
    logic               any;
    exc_cause_e         cause;
    logic [AW-1:0]      vec_addr;
    logic [AW-AW/2-1:0] addr_hi_unused;

    assign addr_hi_unused = mem_addr[AW-1:AW/2];

    exc_align_check #(.AW(AW)) u_align (
        .valid      (mem_valid),
        .size       (acc_size_e'(mem_size)),
        .addr_lo    (mem_addr[1:0]),
        .misaligned (misaligned)
    );

    // request bit order is the priority order, bit 0 highest
    assign req = {tick_expired, insn_trap, insn_syscall, fetch_illegal,
                  misaligned, mem_valid & ~mem_region_hit};

    exc_prio_pick #(.N(NUM_SRC)) u_pick (
        .req   (req),
        .grant (grant),
        .any   (any)
    );

    always_comb begin
        cause = CAUSE_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) cause = exc_cause_e'(3'(i + 1));
        end
        vec_addr = VEC_BASE + AW'(vec_offset(cause));
    end

    exc_state_save #(.AW(AW), .SW(SW), .SUP_BIT(SUP_BIT)) u_save (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (any),
        .ret        (eret),
        .pc_in      (pc_in),
        .status_in  (status_in),
        .epc_q      (saved_pc),
        .esr_q      (saved_status),
        .supervisor (supervisor)
    );

    always_comb begin
        exc_taken      = any;
        exc_cause      = cause;
        redirect_valid = any | eret;
        redirect_pc    = any ? vec_addr : saved_pc;
    end

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
    parameter int            AW       = 32,
    parameter int            SW       = 8,
    parameter int            SUP_BIT  = 0,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_valid,
    input logic [1:0]    mem_size,
    input logic          mem_region_hit,
    input logic          fetch_illegal,
    input logic          insn_syscall,
    input logic          insn_trap,
    input logic          tick_expired,
    input logic          eret,
    input logic [AW-1:0] pc_in,
    input logic [SW-1:0] status_in,
    input logic          exc_taken,
    input logic [2:0]    exc_cause,
    input logic          redirect_valid,
    input logic [AW-1:0] redirect_pc,
    input logic [AW-1:0] saved_pc,
    input logic [SW-1:0] saved_status,
    input logic          supervisor
);

    p_bus_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_region_hit) |->
        (exc_taken && exc_cause == 3'd1 && redirect_pc == VEC_BASE + AW'(12'h200)));

    p_byte_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_region_hit && mem_size == 2'd0) |-> (exc_cause != 3'd2));

    p_state_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (saved_pc == $past(pc_in) && saved_status == $past(status_in)));

    p_super_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> supervisor);

    p_ret_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_taken) |-> (redirect_valid && redirect_pc == saved_pc));

    p_ret_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_taken) |=> (supervisor == $past(saved_status[SUP_BIT])));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && !fetch_illegal && !insn_syscall && !insn_trap &&
         !tick_expired && !eret) |-> (!exc_taken && !redirect_valid));

endmodule

bind exc_vector_unit exc_vector_unit_chk #(
    .AW(AW), .SW(SW), .SUP_BIT(SUP_BIT), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_size(mem_size),
    .mem_region_hit(mem_region_hit), .fetch_illegal(fetch_illegal),
    .insn_syscall(insn_syscall), .insn_trap(insn_trap),
    .tick_expired(tick_expired), .eret(eret), .pc_in(pc_in),
    .status_in(status_in), .exc_taken(exc_taken), .exc_cause(exc_cause),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .saved_pc(saved_pc), .saved_status(saved_status), .supervisor(supervisor)
);

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_valid = 0, mem_region_hit = 1;
    logic [AW-1:0] mem_addr = '0;
    logic [1:0]    mem_size = '0;
    logic          fetch_illegal = 0, insn_syscall = 0, insn_trap = 0;
    logic          tick_expired = 0, eret = 0;
    logic [AW-1:0] pc_in = '0;
    logic [SW-1:0] status_in = '0;
    logic          exc_taken, redirect_valid, supervisor;
    logic [2:0]    exc_cause;
    logic [AW-1:0] redirect_pc, saved_pc;
    logic [SW-1:0] saved_status;

    int n_chk = 0, n_fail = 0;
    logic          done = 0;
    logic [AW-1:0] m_epc = '0;
    logic [SW-1:0] m_esr = '0;
    logic          m_sup = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_region_hit(mem_region_hit),
        .fetch_illegal(fetch_illegal), .insn_syscall(insn_syscall),
        .insn_trap(insn_trap), .tick_expired(tick_expired), .eret(eret),
        .pc_in(pc_in), .status_in(status_in), .exc_taken(exc_taken),
        .exc_cause(exc_cause), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .saved_pc(saved_pc),
        .saved_status(saved_status), .supervisor(supervisor)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_vec(input int c);
        case (c)
            1: return 32'h200;
            2: return 32'h600;
            3: return 32'h700;
            4: return 32'hC00;
            5: return 32'hE00;
            6: return 32'h500;
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle_inputs();
        mem_valid = 0; mem_region_hit = 1; mem_addr = '0; mem_size = '0;
        fetch_illegal = 0; insn_syscall = 0; insn_trap = 0;
        tick_expired = 0; eret = 0;
    endtask

    // called at a negedge with inputs applied; returns at the next negedge, inputs idle
    task automatic run_cycle(input string req, input int ecause, input logic ret);
        logic taken;
        taken = (ecause != 0);
        #2;
        chk({req, " taken"}, 32'(exc_taken), 32'(taken));
        chk({req, " cause"}, 32'(exc_cause), 32'(ecause));
        chk({req, " redirect_valid"}, 32'(redirect_valid), 32'(taken | ret));
        if (taken)    chk({req, " vector"}, redirect_pc, exp_vec(ecause));
        else if (ret) chk({req, " R10 return pc"}, redirect_pc, m_epc);
        @(posedge clk);
        if (taken) begin
            m_epc = pc_in; m_esr = status_in; m_sup = 1'b1;
        end else if (ret) begin
            m_sup = m_esr[0];
        end
        #1;
        chk({req, " R8 saved_pc"}, saved_pc, m_epc);
        chk({req, " R8 saved_status"}, 32'(saved_status), 32'(m_esr));
        chk({req, " R9/R10 supervisor"}, 32'(supervisor), 32'(m_sup));
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 supervisor", 32'(supervisor), 32'h1);
        chk("R1 saved_pc", saved_pc, 32'h0);
        chk("R1 saved_status", 32'(saved_status), 32'h0);
        chk("R1 exc_taken", 32'(exc_taken), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every size code against every low address pattern
        for (int sz = 0; sz < 4; sz++) begin
            for (int lo = 0; lo < 8; lo++) begin
                logic mis;
                mis = (sz == 0) ? 1'b0 : (sz == 1) ? lo[0] : (lo[1:0] != 2'b00);
                mem_valid = 1; mem_region_hit = 1; mem_size = 2'(sz);
                mem_addr = 32'h0000_4000 + 32'(lo);
                pc_in = 32'h100 + 32'(sz * 32 + lo * 4);
                status_in = 8'(sz * 8 + lo) | 8'h01;
                run_cycle("R3 align sweep", mis ? 2 : 0, 1'b0);
            end
        end

        // R2 R4 R5 R6 R7: all cause combinations
        for (int m = 0; m < 64; m++) begin
            int ec;
            ec = 0;
            for (int b = 5; b >= 0; b--) if (m[b]) ec = b + 1;
            mem_valid = m[0] | m[1];
            mem_region_hit = ~m[0];
            mem_size = 2'd2;
            mem_addr = m[1] ? 32'h0000_8002 : 32'h0000_8000;
            fetch_illegal = m[2]; insn_syscall = m[3];
            insn_trap = m[4]; tick_expired = m[5];
            pc_in = 32'h2000 + 32'(m * 4);
            status_in = 8'(m) | 8'h01;
            run_cycle("R7 priority (R2 R4 R5 R6)", ec, 1'b0);
        end

        // R10: save a status with supervisor bit clear, then return to user mode
        insn_syscall = 1; pc_in = 32'h3000; status_in = 8'hA4;
        run_cycle("R5 syscall", 4, 1'b0);
        eret = 1;
        run_cycle("R10 return to user", 0, 1'b1);
        chk("R10 user mode", 32'(supervisor), 32'h0);
        // R9: exception from user mode
        tick_expired = 1; pc_in = 32'h3100; status_in = 8'h5B;
        run_cycle("R9 tick from user (R6)", 6, 1'b0);
        chk("R9 supervisor after user exc", 32'(supervisor), 32'h1);
        eret = 1;
        run_cycle("R10 return keeps supervisor", 0, 1'b1);
        // R10: exception in the return cycle wins
        eret = 1; fetch_illegal = 1; pc_in = 32'h3200; status_in = 8'h22;
        run_cycle("R10 eret with illegal (R4)", 3, 1'b0);

        // R11: quiet cycles and ungated bad addresses
        run_cycle("R11 idle", 0, 1'b0);
        mem_valid = 0; mem_region_hit = 0; mem_size = 2'd2; mem_addr = 32'h3;
        pc_in = 32'h9999; status_in = 8'hFF;
        run_cycle("R11 strobe low", 0, 1'b0);
        chk("R11 saved_pc unchanged", saved_pc, 32'h3200);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule